// File: doc/BRIEF.md
# Per-Processor Dual-Mode Counter Timer

This block is one processor's private counter/timer. A 32-bit word-addressed register port reaches it, and a mode select input, driven from a chip-level mode register, decides how it behaves. With the select low it is a periodic limit timer. The count rises one unit per tick, wraps to zero when it reaches the programmed limit, and sets a reached flag that drives the interrupt line. Reading the limit word clears that flag.

With the select high the same count register becomes a free-running 63-bit counter. Software can stop and restart it. It is read as two 32-bit halves and never interrupts. Any change of the select restarts the counter from zero, leaves it running and lowers the interrupt.

One count unit is worth bit 9 of the visible value, so bits 8..0 always read as zero. A unit is added every `TICK_CYCLES` clock cycles, which gives 500 ns at the default setting on a 250 MHz clock. Word offsets on the port are 0 (limit / high half), 1 (count / low half), 2 (limit without restart) and 3 (run control).

Top module: `pcpu_ctmr`

## Requirements
- R1: After reset the counter runs from a zero count, the interrupt is low, word 3 reads 1, and word 0 reads the limit 0x7FFFFE00.
- R2: While running, the count advances by one unit (value 0x200 on the port) every `TICK_CYCLES` clock cycles, counted from the last restart; bits 8..0 of any count read are zero.
- R3: In limit mode a write to word 0 loads the limit from data bits 30..9, a zero field standing for 0x7FFFFE00, and restarts the count from zero with the interrupt lowered.
- R4: In limit mode, on the tick that would bring the count to the limit, the count returns to zero and the reached flag and interrupt rise; this repeats every limit period.
- R5: In limit mode word 1 reads {reached in bit 31, count bits 30..9, zeros}; a read of word 0 returns the limit in bits 30..9 and clears the reached flag and the interrupt.
- R6: In limit mode a write to word 2 loads the limit the same way without restarting the count.
- R7: In user mode word 1 reads bits 31..0 of the 63-bit count value and captures bits 63..32 at that instant; word 0 returns the captured upper half.
- R8: In user mode a write to word 0 or word 1 restarts the count from zero whatever the data.
- R9: In user mode a write to word 3 sets the run state to data bit 0; a stopped count holds its value; word 3 reads the run state in bit 0.
- R10: In limit mode writes to word 3 are ignored and the counter always runs.
- R11: In user mode the interrupt stays low.
- R12: A change of the mode select restarts the count from zero, sets the run state, lowers the interrupt and sets the limit to 0x7FFFFE00.
- R13: Read data appears with the valid strobe one cycle after the read request; word 2 and words 4 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| user_sel | input | 1 | Mode select: 1 selects the free-running user counter |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read request for one cycle |
| bus_word | input | 3 | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Interrupt, high while the reached flag is set |

## Verification
The bench programs short limits so that the interrupt edge and the wrap can be pinned to an exact cycle. An off-by-one terminal compare would fire one period early or late. A word 2 write that wrongly restarted the count would shift the second wrap. The bench checks that reading word 0 clears the interrupt while reading word 1 leaves it set, because a design that swapped those side effects would lose or stick interrupts. In user mode it stops the counter partway through a tick period and resumes it. Any design that dropped or reset the prescaler phase would then read a different count. Mode switches taken with the interrupt high and the counter stopped must come back running, zeroed and quiet.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  localparam int DATA_W   = 32;
  localparam int WORD_W   = 3;
  localparam int UNIT_LSB = 9;                       // weight of one count unit
  localparam int FULL_W   = 64;                      // user-mode value width on the port
  localparam int CNT_W    = FULL_W - 1 - UNIT_LSB;   // count units held (bits 62..9)
  localparam int LIM_W    = DATA_W - 1 - UNIT_LSB;   // limit units held (bits 30..9)

  localparam logic [LIM_W-1:0] LIM_MAX = '1;

  typedef enum logic [WORD_W-1:0] {
    WD_HIGH_LIMIT = 3'd0,
    WD_LOW_COUNT  = 3'd1,
    WD_LIMIT_KEEP = 3'd2,
    WD_RUN_CTRL   = 3'd3
  } word_e;

  // limit field from a data word; an all-zero field means the maximum
  function automatic logic [LIM_W-1:0] limit_from_data(input logic [DATA_W-1:0] d);
    logic [LIM_W-1:0] u;
    u = d[UNIT_LSB +: LIM_W];
    return (u == '0) ? LIM_MAX : u;
  endfunction

  // true when the next unit would reach (or pass) the limit
  function automatic logic limit_terminal(input logic [LIM_W-1:0] c,
                                          input logic [LIM_W-1:0] lim);
    logic [LIM_W:0] nxt;
    nxt = {1'b0, c} + (LIM_W+1)'(1);
    return nxt >= {1'b0, lim};
  endfunction

  function automatic logic [FULL_W-1:0] user_value(input logic [CNT_W-1:0] c);
    return {1'b0, c, {UNIT_LSB{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] limit_word(input logic [LIM_W-1:0] lim);
    return {1'b0, lim, {UNIT_LSB{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] count_word(input logic reached,
                                                   input logic [LIM_W-1:0] c);
    return {reached, c, {UNIT_LSB{1'b0}}};
  endfunction

endpackage

// File: rtl/ctmr_tick_gen.sv
module ctmr_tick_gen #(
  parameter int TICK_CYCLES = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] phase_q;
  logic          wrap;

  assign wrap = (phase_q == LAST);
  assign tick = enable && !restart && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (enable)  phase_q <= wrap ? '0 : phase_q + PW'(1);
  end
endmodule

// File: rtl/ctmr_count_core.sv
module ctmr_count_core
  import ctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_q,
  input  logic              mode_chg,
  input  logic              restart,
  input  logic              lim_load,
  input  logic              run_load,
  input  logic              lim_ack,
  input  logic              tick,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [LIM_W-1:0]  limit_q,
  output logic              running_q,
  output logic              reached_q,
  output logic              run_active,
  output logic              lim_event
);
  logic term;

  assign term       = limit_terminal(cnt_q[LIM_W-1:0], limit_q);
  assign run_active = !user_q || running_q;
  assign lim_event  = tick && !restart && !user_q && term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit_q <= LIM_MAX;
    else if (mode_chg) limit_q <= LIM_MAX;
    else if (lim_load) limit_q <= limit_from_data(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        running_q <= 1'b1;
    else if (mode_chg) running_q <= 1'b1;
    else if (run_load) running_q <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick) begin
      if (!user_q && term) cnt_q <= '0;
      else                 cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reached_q <= 1'b0;
    else if (restart)   reached_q <= 1'b0;
    else if (lim_event) reached_q <= 1'b1;
    else if (lim_ack)   reached_q <= 1'b0;
  end
endmodule

// File: rtl/ctmr_rdmux.sv
module ctmr_rdmux
  import ctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_q,
  input  logic              restart,
  input  logic              rd_en,
  input  logic              capture,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [LIM_W-1:0]  limit,
  input  logic              reached,
  input  logic              running,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [FULL_W-1:0] full;
  logic [DATA_W-1:0] hi_shadow_q;
  logic [DATA_W-1:0] rd_next;

  assign full = user_value(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_shadow_q <= '0;
    else if (restart) hi_shadow_q <= '0;
    else if (capture) hi_shadow_q <= full[FULL_W-1:DATA_W];
  end

  always_comb begin
    rd_next = '0;
    case (word)
      WD_HIGH_LIMIT: rd_next = user_q ? hi_shadow_q : limit_word(limit);
      WD_LOW_COUNT:  rd_next = user_q ? full[DATA_W-1:0]
                                      : count_word(reached, cnt[LIM_W-1:0]);
      WD_RUN_CTRL:   rd_next = {{(DATA_W-1){1'b0}}, running};
      default:       rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/pcpu_ctmr.sv
module pcpu_ctmr
  import ctmr_pkg::*;
#(
  parameter int TICK_CYCLES = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  logic user_q;
  logic mode_chg;
  logic wr_hi, wr_lo, wr_keep, wr_run;
  logic clr_wr, restart, lim_load, run_load, lim_ack, lo_capture;
  logic tick, run_active, lim_event;
  logic [CNT_W-1:0] cnt_q;
  logic [LIM_W-1:0] limit_q;
  logic running_q, reached_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) user_q <= 1'b0;
    else        user_q <= user_sel;
  end

  // named events for the checker
  assign mode_chg   = (user_sel != user_q);
  assign wr_hi      = bus_wr && (bus_word == WD_HIGH_LIMIT);
  assign wr_lo      = bus_wr && (bus_word == WD_LOW_COUNT);
  assign wr_keep    = bus_wr && (bus_word == WD_LIMIT_KEEP);
  assign wr_run     = bus_wr && (bus_word == WD_RUN_CTRL);
  assign clr_wr     = user_q ? (wr_hi || wr_lo) : wr_hi;
  assign restart    = mode_chg || clr_wr;
  assign lim_load   = !user_q && !mode_chg && (wr_hi || wr_keep);
  assign run_load   = user_q && !mode_chg && wr_run;
  assign lim_ack    = !user_q && bus_rd && (bus_word == WD_HIGH_LIMIT);
  assign lo_capture = user_q && bus_rd && (bus_word == WD_LOW_COUNT);

  ctmr_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .enable  (run_active),
    .tick    (tick)
  );

  ctmr_count_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .user_q     (user_q),
    .mode_chg   (mode_chg),
    .restart    (restart),
    .lim_load   (lim_load),
    .run_load   (run_load),
    .lim_ack    (lim_ack),
    .tick       (tick),
    .wdata      (bus_wdata),
    .cnt_q      (cnt_q),
    .limit_q    (limit_q),
    .running_q  (running_q),
    .reached_q  (reached_q),
    .run_active (run_active),
    .lim_event  (lim_event)
  );

  ctmr_rdmux u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .user_q  (user_q),
    .restart (restart),
    .rd_en   (bus_rd),
    .capture (lo_capture),
    .word    (bus_word),
    .cnt     (cnt_q),
    .limit   (limit_q),
    .reached (reached_q),
    .running (running_q),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

  assign irq = reached_q;
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk
  import ctmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             user_q,
  input logic             mode_chg,
  input logic             clr_wr,
  input logic             lim_event,
  input logic             tick,
  input logic             running,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             bus_rd,
  input logic             bus_rvalid
);
  AST_USER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    user_q |-> !irq);                                                    // R11
  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt == '0 && running && !irq));                        // R12
  AST_LIMIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !user_q && !mode_chg) |=> (cnt == '0 && !irq));           // R3
  AST_USER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && user_q && !mode_chg) |=> (cnt == '0));                    // R8
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (user_q && !running && !mode_chg && !clr_wr) |=> $stable(cnt));      // R9
  AST_LIMIT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    !user_q |-> running);                                                // R10
  AST_TERM_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    lim_event |=> irq);                                                  // R4
  AST_USER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && user_q && !mode_chg && !clr_wr) |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);                                              // R13
endmodule

bind pcpu_ctmr ctmr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .user_q     (user_q),
  .mode_chg   (mode_chg),
  .clr_wr     (clr_wr),
  .lim_event  (lim_event),
  .tick       (tick),
  .running    (running_q),
  .cnt        (cnt_q),
  .irq        (irq),
  .bus_rd     (bus_rd),
  .bus_rvalid (bus_rvalid)
);

// File: tb/tb_pcpu_ctmr.sv
module tb_pcpu_ctmr;
  localparam int N = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, user_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq;

  pcpu_ctmr #(.TICK_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .user_sel(user_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mon_exp;
  string       mon_tag;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (bus_rvalid === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R13 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        check(mon_tag, bus_rdata, mon_exp);
      end
    end
  end

  function automatic int units(input int k);
    return k / N;
  endfunction

  task automatic upto(input int x);
    while (cyc < x) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d, output int e);
    @(negedge clk); bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(posedge clk); #1; e = cyc; bus_wr = 1'b0;
  endtask

  // the read samples the state present after the current edge count
  task automatic rd(input logic [2:0] w, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_word = w;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1; bus_rd = 1'b0;
  endtask

  task automatic set_mode(input logic v, output int e);
    @(negedge clk); user_sel = v;
    @(posedge clk); #1; e = cyc;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r0, e, f, g, h, j, m, s, rr, z, y, b, tmp, frozen, ph;
    repeat (5) @(posedge clk); #1;
    check("R1 irq low in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1; r0 = cyc;
    check("R1 irq low after reset", {31'b0, irq}, 32'h0);
    rd(3'd3, 32'h1, "R1 running at reset");
    rd(3'd0, 32'h7FFFFE00, "R1 limit at reset");
    upto(r0 + 9);
    rd(3'd1, 32'(units(cyc - r0) << 9), "R2 count advances per tick");
    rd(3'd2, 32'h0, "R13 word2 reads zero");
    rd(3'd5, 32'h0, "R13 word5 reads zero");

    // limit 5 units, low bits of data ignored
    wr(3'd0, 32'h0000_0BFF, e);
    rd(3'd1, 32'h0, "R3 limit write restarts count");
    upto(e + 19); check("R4 irq low before terminal", {31'b0, irq}, 32'h0);
    upto(e + 20); check("R4 irq at terminal", {31'b0, irq}, 32'h1);
    upto(e + 21);
    rd(3'd1, 32'h8000_0000, "R4 wrapped count with reached bit");
    rd(3'd0, 32'h0000_0A00, "R5 limit readback");
    check("R5 limit read clears irq", {31'b0, irq}, 32'h0);
    rd(3'd1, 32'h0, "R5 reached cleared by limit read");
    upto(e + 40); check("R4 periodic second terminal", {31'b0, irq}, 32'h1);

    // limit without restart
    wr(3'd0, 32'h0000_0A00, f);
    upto(f + 8);
    wr(3'd2, 32'h0000_0E00, tmp);
    upto(f + 20); check("R6 old limit no longer fires", {31'b0, irq}, 32'h0);
    upto(f + 27); check("R6 irq low before new limit", {31'b0, irq}, 32'h0);
    upto(f + 28); check("R6 new limit fires without restart", {31'b0, irq}, 32'h1);
    upto(f + 29);
    rd(3'd1, 32'h8000_0000, "R6 count wrapped at new limit");
    rd(3'd0, 32'h0000_0E00, "R6 limit value kept");

    wr(3'd0, 32'h0, g);
    rd(3'd0, 32'h7FFFFE00, "R3 zero limit maps to maximum");

    wr(3'd3, 32'h0, h);
    rd(3'd3, 32'h1, "R10 run write ignored in limit mode");
    upto(h + 12);
    rd(3'd1, 32'(units(cyc - g) << 9), "R10 counter keeps running");

    // raise irq, then switch to user mode
    wr(3'd0, 32'h0000_0400, j);
    upto(j + 8); check("R4 short limit fires", {31'b0, irq}, 32'h1);
    set_mode(1'b1, m);
    check("R12 mode change lowers irq", {31'b0, irq}, 32'h0);
    rd(3'd3, 32'h1, "R12 running after mode change");
    upto(m + 20);
    rd(3'd1, 32'(units(cyc - m) << 9), "R7 user low word");
    rd(3'd0, 32'h0, "R7 captured high word");

    upto(m + 29);
    wr(3'd3, 32'h0, s);
    frozen = units(s - m); ph = (s - m) % N;
    upto(s + 20);
    rd(3'd1, 32'(frozen << 9), "R9 stopped count holds");
    rd(3'd3, 32'h0, "R9 stopped status");
    check("R11 no irq in user mode", {31'b0, irq}, 32'h0);
    wr(3'd3, 32'h1, rr);
    upto(rr + 10);
    rd(3'd1, 32'((frozen + (ph + cyc - rr) / N) << 9), "R9 resumed keeps prescaler phase");

    wr(3'd0, 32'hDEADBEEF, z);
    rd(3'd1, 32'h0, "R8 high word write restarts");
    upto(z + 8);
    rd(3'd1, 32'(units(cyc - z) << 9), "R8 count runs after restart");
    wr(3'd1, 32'h12345678, y);
    upto(y + 5);
    rd(3'd1, 32'(units(cyc - y) << 9), "R8 low word write restarts");
    check("R11 irq still low in user mode", {31'b0, irq}, 32'h0);

    wr(3'd3, 32'h0, tmp);
    set_mode(1'b0, b);
    rd(3'd3, 32'h1, "R12 running after return to limit mode");
    rd(3'd0, 32'h7FFFFE00, "R12 limit maximum after mode change");
    upto(b + 6);
    rd(3'd1, 32'(units(cyc - b) << 9), "R12 count restarted on mode change");

    repeat (3) @(posedge clk); #1;
    check("R13 every read answered", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule